// File: doc/BRIEF.md
# Threshold Offset Register File

This block keeps the two distances that drive a FIFO's early-warning flags: the near-empty distance, used by flag logic on the read clock, and the near-full distance, used by flag logic on the write clock. Each distance is stored as a low part and a high part, which gives four small registers. Software and expansion logic reach these registers over the FIFO's own data pins while the dual-purpose load pin is held low. No address is involved. A write-side pointer and a separate read-side pointer each step through the four registers in a fixed cyclic order, and each pointer stays where it stopped when a load burst ends.

The dual-purpose pin is sampled while reset is active. If the pin is low during reset, the block runs in load mode and the pin acts as a load strobe. If the pin is high during reset, it is a plain second write enable and the registers can no longer be reached. The near-full value is written and used in the write-clock domain. Both values are carried into the read-clock domain by a toggle request/acknowledge transfer. That copy feeds the near-empty flag and the read-back path.

Top module: `thresh_ofs_regfile`

## Requirements
- R1: After reset both distances equal the parameter default (7). Both pointers select the near-empty low register, and the read-back port shows zero.
- R2: Load writes (load low, write enable low, on a rising write clock) fill the registers in a fixed order. The order is near-empty low, near-empty high, near-full low, near-full high. The fifth write returns to near-empty low.
- R3: When load goes high in the middle of a sequence, the write pointer keeps its position. The next load write goes to the register after the last one written.
- R4: Load reads (load low, both read enables low, on a rising read clock) return the registers in the same four-step order on the read-back port. The low part occupies data bits [8:0]. The high part sits right-aligned, with zeros above it.
- R5: A high register keeps only the address bits above the low nine (4 bits by default). Data bits above that width are dropped and read back as zero.
- R6: With load high and write enable low, the normal FIFO write strobe is asserted and no offset register changes. With both load and write enable high, nothing is written at all.
- R7: If the dual-purpose pin was high during reset, load-low accesses change no register and return no data. In that mode the pin gates FIFO writes as a second enable, and FIFO reads are not diverted.
- R8: A load read suppresses the normal FIFO read strobe. With load high, both read enables low assert the FIFO read strobe and leave the read-back port unchanged.
- R9: A new near-empty distance appears on the read-clock output within a bounded number of cycles. The transferred copy changes only when a complete request arrives.
- R10: A new near-full distance appears on the write-clock output on the first write-clock edge after the load write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst | input | 1 | Synchronous active-high reset, held across edges of both clocks |
| ld_n | input | 1 | Dual-purpose pin: load strobe (active low) or second write enable (active high) |
| wen1_n | input | 1 | Write enable, active low |
| ren1_n | input | 1 | Read enable one, active low |
| ren2_n | input | 1 | Read enable two, active low |
| din | input | DW (9) | FIFO data input, also carries offset values |
| fifo_wr_en | output | 1 | Normal FIFO write strobe |
| fifo_rd_en | output | 1 | Normal FIFO read strobe |
| full_ofs | output | AW (13) | Near-full distance, write-clock domain |
| empty_ofs | output | AW (13) | Near-empty distance, read-clock domain |
| ofs_rdata | output | DW (9) | Offset read-back data |

## Verification
A write pointer that slips, or one that resets to the wrong register, puts the wrong value on full_ofs one write-clock edge after the affected load write. It also skews every later read-back word. A read-pointer fault shows on the first load read after it. A stalled or torn transfer leaves empty_ofs at its old value, or gives a mixed value, after the settling window of a few tens of cycles. A mode bit captured wrongly shows at once on the FIFO strobes.

// File: rtl/ofsrf_pkg.sv
package ofsrf_pkg;

    typedef enum logic [1:0] {
        SEL_ELO = 2'd0,
        SEL_EHI = 2'd1,
        SEL_FLO = 2'd2,
        SEL_FHI = 2'd3
    } ofs_sel_t;

    function automatic ofs_sel_t sel_next(ofs_sel_t s);
        return ofs_sel_t'(s + 2'd1);
    endfunction

endpackage

// File: rtl/ofsrf_sync.sv
module ofsrf_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    generate
        if (STAGES < 2) begin : g_one
            logic q_r;
            always_ff @(posedge clk) begin
                if (rst) q_r <= 1'b0;
                else     q_r <= d;
            end
            assign q = q_r;
        end else begin : g_chain
            logic [STAGES-1:0] ch;
            always_ff @(posedge clk) begin
                if (rst) ch <= '0;
                else     ch <= {ch[STAGES-2:0], d};
            end
            assign q = ch[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/ofsrf_wr_bank.sv
module ofsrf_wr_bank
    import ofsrf_pkg::*;
#(
    parameter int DW      = 9,
    parameter int AW      = 13,
    parameter int DEF_OFS = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ld_n,
    input  logic          wen1_n,
    input  logic [DW-1:0] din,
    output logic [AW-1:0] n_o,
    output logic [AW-1:0] m_o
);
    localparam int HW = AW - DW;
    localparam logic [AW-1:0] DEF_V = AW'(DEF_OFS);

    logic          load_mode;
    ofs_sel_t      wsel;
    logic [DW-1:0] e_lo, f_lo;
    logic [HW-1:0] e_hi, f_hi;
    logic          ld_wr;

    // register write only when configured for load and both strobes low
    assign ld_wr = load_mode & ~ld_n & ~wen1_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            load_mode <= ~ld_n;
            wsel      <= SEL_ELO;
            e_lo      <= DEF_V[DW-1:0];
            e_hi      <= DEF_V[AW-1:DW];
            f_lo      <= DEF_V[DW-1:0];
            f_hi      <= DEF_V[AW-1:DW];
        end else if (ld_wr) begin
            unique case (wsel)
                SEL_ELO: e_lo <= din;
                SEL_EHI: e_hi <= din[HW-1:0];
                SEL_FLO: f_lo <= din;
                SEL_FHI: f_hi <= din[HW-1:0];
            endcase
            wsel <= sel_next(wsel);
        end
    end

    assign n_o = {e_hi, e_lo};
    assign m_o = {f_hi, f_lo};

    a_r3_sel_holds: assert property (@(posedge clk) disable iff (rst)
        !ld_wr |=> $stable(wsel));
    a_r7_dual_sel_idle: assert property (@(posedge clk) disable iff (rst)
        !load_mode |-> (wsel == SEL_ELO));
    a_r7_dual_regs_frozen: assert property (@(posedge clk) disable iff (rst)
        !load_mode |=> ($stable(m_o) && $stable(n_o)));
endmodule

// File: rtl/ofsrf_xfer.sv
module ofsrf_xfer #(
    parameter int            W       = 26,
    parameter int            STAGES  = 2,
    parameter logic [W-1:0]  RST_VAL = '0
) (
    input  logic         src_clk,
    input  logic         src_rst,
    input  logic [W-1:0] src_data,
    input  logic         dst_clk,
    input  logic         dst_rst,
    output logic [W-1:0] dst_data
);
    logic [W-1:0] hold;
    logic         req_t, ack_s, busy;
    logic         req_s, seen;
    logic [W-1:0] copy;

    assign busy = req_t ^ ack_s;

    // source side: snapshot is frozen while a request is outstanding
    always_ff @(posedge src_clk) begin
        if (src_rst) begin
            hold  <= RST_VAL;
            req_t <= 1'b0;
        end else if (!busy && (src_data != hold)) begin
            hold  <= src_data;
            req_t <= ~req_t;
        end
    end

    ofsrf_sync #(.STAGES(STAGES)) u_req_sync (
        .clk(dst_clk), .rst(dst_rst), .d(req_t), .q(req_s));

    always_ff @(posedge dst_clk) begin
        if (dst_rst) begin
            seen <= 1'b0;
            copy <= RST_VAL;
        end else if (req_s != seen) begin
            seen <= req_s;
            copy <= hold;
        end
    end

    ofsrf_sync #(.STAGES(STAGES)) u_ack_sync (
        .clk(src_clk), .rst(src_rst), .d(seen), .q(ack_s));

    assign dst_data = copy;

    a_r9_hold_stable: assert property (@(posedge src_clk) disable iff (src_rst)
        busy |=> $stable(hold));
    a_r9_copy_on_request: assert property (@(posedge dst_clk) disable iff (dst_rst)
        (copy != $past(copy)) |-> (seen != $past(seen)));
endmodule

// File: rtl/ofsrf_rd_port.sv
module ofsrf_rd_port
    import ofsrf_pkg::*;
#(
    parameter int DW = 9,
    parameter int AW = 13
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ld_n,
    input  logic          ren1_n,
    input  logic          ren2_n,
    input  logic [AW-1:0] n_i,
    input  logic [AW-1:0] m_i,
    output logic [DW-1:0] rdata,
    output logic          fifo_rd_en
);
    localparam int HW = AW - DW;
    localparam int PW = DW - HW;

    logic          load_mode;
    ofs_sel_t      rsel;
    logic          both_ren, ld_rd;
    logic [DW-1:0] word;

    assign both_ren   = ~ren1_n & ~ren2_n;
    assign ld_rd      = load_mode & ~ld_n & both_ren;
    assign fifo_rd_en = both_ren & ~(load_mode & ~ld_n);

    always_comb begin
        unique case (rsel)
            SEL_ELO: word = n_i[DW-1:0];
            SEL_EHI: word = {{PW{1'b0}}, n_i[AW-1:DW]};
            SEL_FLO: word = m_i[DW-1:0];
            SEL_FHI: word = {{PW{1'b0}}, m_i[AW-1:DW]};
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            load_mode <= ~ld_n;
            rsel      <= SEL_ELO;
            rdata     <= '0;
        end else if (ld_rd) begin
            rdata <= word;
            rsel  <= sel_next(rsel);
        end
    end

    a_r4_rdata_hold: assert property (@(posedge clk) disable iff (rst)
        !ld_rd |=> $stable(rdata));
    a_r8_rd_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(fifo_rd_en && ld_rd));
endmodule

// File: rtl/thresh_ofs_regfile.sv
module thresh_ofs_regfile #(
    parameter int DW      = 9,
    parameter int AW      = 13,
    parameter int DEF_OFS = 7,
    parameter int STAGES  = 2
) (
    input  logic          wclk,
    input  logic          rclk,
    input  logic          rst,
    input  logic          ld_n,
    input  logic          wen1_n,
    input  logic          ren1_n,
    input  logic          ren2_n,
    input  logic [DW-1:0] din,
    output logic          fifo_wr_en,
    output logic          fifo_rd_en,
    output logic [AW-1:0] full_ofs,
    output logic [AW-1:0] empty_ofs,
    output logic [DW-1:0] ofs_rdata
);
    localparam int PAIR_W = 2 * AW;
    localparam logic [PAIR_W-1:0] PAIR_DEF = {AW'(DEF_OFS), AW'(DEF_OFS)};

    logic [AW-1:0]     w_n, w_m, r_n, r_m;
    logic [PAIR_W-1:0] r_pair;

    // load high with enable low is a plain write in either pin mode
    assign fifo_wr_en = ~wen1_n & ld_n;

    ofsrf_wr_bank #(.DW(DW), .AW(AW), .DEF_OFS(DEF_OFS)) u_wr (
        .clk(wclk), .rst(rst), .ld_n(ld_n), .wen1_n(wen1_n),
        .din(din), .n_o(w_n), .m_o(w_m));

    ofsrf_xfer #(.W(PAIR_W), .STAGES(STAGES), .RST_VAL(PAIR_DEF)) u_xfer (
        .src_clk(wclk), .src_rst(rst), .src_data({w_m, w_n}),
        .dst_clk(rclk), .dst_rst(rst), .dst_data(r_pair));

    assign r_n = r_pair[AW-1:0];
    assign r_m = r_pair[PAIR_W-1:AW];

    ofsrf_rd_port #(.DW(DW), .AW(AW)) u_rd (
        .clk(rclk), .rst(rst), .ld_n(ld_n), .ren1_n(ren1_n), .ren2_n(ren2_n),
        .n_i(r_n), .m_i(r_m), .rdata(ofs_rdata), .fifo_rd_en(fifo_rd_en));

    assign full_ofs  = w_m;
    assign empty_ofs = r_n;

    a_r6_plain_write_keeps: assert property (@(posedge wclk) disable iff (rst)
        fifo_wr_en |=> $stable(full_ofs));
endmodule

// File: tb/thresh_ofs_regfile_test.sv
module thresh_ofs_regfile_test;
    localparam int DW = 9;
    localparam int AW = 13;

    logic wclk = 1'b0, rclk = 1'b0;
    logic rst = 1'b1, ld_n = 1'b0, wen1_n = 1'b1, ren1_n = 1'b1, ren2_n = 1'b1;
    logic [DW-1:0] din = '0;
    logic fifo_wr_en, fifo_rd_en;
    logic [AW-1:0] full_ofs, empty_ofs;
    logic [DW-1:0] ofs_rdata;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #2 wclk = ~wclk;
    initial begin #1; forever #2 rclk = ~rclk; end

    thresh_ofs_regfile uut (
        .wclk(wclk), .rclk(rclk), .rst(rst), .ld_n(ld_n), .wen1_n(wen1_n),
        .ren1_n(ren1_n), .ren2_n(ren2_n), .din(din), .fifo_wr_en(fifo_wr_en),
        .fifo_rd_en(fifo_rd_en), .full_ofs(full_ofs), .empty_ofs(empty_ofs),
        .ofs_rdata(ofs_rdata));

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic do_reset(bit pin);
        @(negedge wclk);
        ld_n = pin; wen1_n = 1'b1; ren1_n = 1'b1; ren2_n = 1'b1; rst = 1'b1;
        repeat (6) @(negedge wclk);
        rst = 1'b0;
        @(negedge wclk);
        ld_n = 1'b1;
    endtask

    task automatic wr_word(logic [DW-1:0] v);
        @(negedge wclk);
        ld_n = 1'b0; wen1_n = 1'b0; din = v;
        @(negedge wclk);
        wen1_n = 1'b1;
    endtask

    task automatic end_burst();
        @(negedge wclk);
        ld_n = 1'b1;
    endtask

    task automatic settle();
        repeat (30) @(negedge wclk);
    endtask

    task automatic rd_word(output int v);
        @(negedge rclk);
        ren1_n = 1'b0; ren2_n = 1'b0;
        @(negedge rclk);
        ren1_n = 1'b1; ren2_n = 1'b1;
        v = int'(ofs_rdata);
    endtask

    task automatic t_reset();
        int v;
        chk("R1 full default", int'(full_ofs), 7);
        chk("R1 empty default", int'(empty_ofs), 7);
        chk("R1 readback zero", int'(ofs_rdata), 0);
        chk("R1 no write strobe", int'(fifo_wr_en), 0);
        @(negedge wclk); ld_n = 1'b0;
        rd_word(v); chk("R1 R4 read elo", v, 7);
        rd_word(v); chk("R4 read ehi", v, 0);
        rd_word(v); chk("R4 read flo", v, 7);
        rd_word(v); chk("R4 read fhi", v, 0);
        end_burst();
    endtask

    task automatic t_sequence();
        wr_word(9'h0A5); chk("R2 elo leaves full", int'(full_ofs), 7);
        wr_word(9'h003);
        wr_word(9'h1C2); chk("R10 full low written", int'(full_ofs), 450);
        wr_word(9'h005); chk("R10 full high written", int'(full_ofs), 3010);
        end_burst();
        settle();
        chk("R9 empty transferred", int'(empty_ofs), 1701);
        wr_word(9'h011);
        end_burst();
        settle();
        chk("R2 fifth write wraps", int'(empty_ofs), 1553);
        chk("R2 full untouched by wrap", int'(full_ofs), 3010);
    endtask

    task automatic t_partial();
        repeat (3) @(negedge wclk);
        wr_word(9'h1FF);
        end_burst();
        settle();
        chk("R5 high part masked", int'(empty_ofs), 7697);
        wr_word(9'h020);
        end_burst();
        chk("R3 resumes at full low", int'(full_ofs), 2592);
        wr_word(9'h000);
        end_burst();
        chk("R3 resumes at full high", int'(full_ofs), 32);
    endtask

    task automatic t_readback();
        int v;
        @(negedge wclk); ld_n = 1'b0; wen1_n = 1'b1;
        settle();
        rd_word(v); chk("R4 read elo", v, 9'h011);
        rd_word(v); chk("R4 R5 read ehi zero padded", v, 9'h00F);
        rd_word(v); chk("R4 read flo", v, 9'h020);
        rd_word(v); chk("R4 read fhi", v, 9'h000);
        end_burst();
        @(negedge wclk); ld_n = 1'b0;
        rd_word(v); chk("R4 read wraps to elo", v, 9'h011);
        end_burst();
    endtask

    task automatic t_plain();
        @(negedge wclk); ld_n = 1'b1; wen1_n = 1'b0; din = 9'h1AB;
        #1 chk("R6 fifo write strobe", int'(fifo_wr_en), 1);
        repeat (2) @(negedge wclk);
        wen1_n = 1'b1;
        chk("R6 full unchanged", int'(full_ofs), 32);
        #1 chk("R6 idle no strobe", int'(fifo_wr_en), 0);
        settle();
        chk("R6 empty unchanged", int'(empty_ofs), 7697);
        @(negedge rclk); ren1_n = 1'b0; ren2_n = 1'b0;
        #1 chk("R8 fifo read strobe", int'(fifo_rd_en), 1);
        @(negedge rclk); ren1_n = 1'b1; ren2_n = 1'b1;
        chk("R8 readback untouched", int'(ofs_rdata), 9'h011);
        @(negedge wclk); ld_n = 1'b0;
        @(negedge rclk); ren1_n = 1'b0; ren2_n = 1'b0;
        #1 chk("R8 load read steals strobe", int'(fifo_rd_en), 0);
        @(negedge rclk); ren1_n = 1'b1; ren2_n = 1'b1;
        chk("R8 load read advances", int'(ofs_rdata), 9'h00F);
        end_burst();
    endtask

    task automatic t_dual();
        do_reset(1'b1);
        @(negedge wclk); ld_n = 1'b0; wen1_n = 1'b0; din = 9'h055;
        #1 chk("R7 pin low blocks fifo write", int'(fifo_wr_en), 0);
        repeat (3) @(negedge wclk);
        wen1_n = 1'b1;
        chk("R7 full unchanged", int'(full_ofs), 7);
        settle();
        chk("R7 empty unchanged", int'(empty_ofs), 7);
        @(negedge rclk); ren1_n = 1'b0; ren2_n = 1'b0;
        #1 chk("R7 reads not diverted", int'(fifo_rd_en), 1);
        @(negedge rclk); ren1_n = 1'b1; ren2_n = 1'b1;
        chk("R7 no readback data", int'(ofs_rdata), 0);
        end_burst();
    endtask

    initial begin
        repeat (50000) @(posedge wclk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        do_reset(1'b0);
        t_reset();
        t_sequence();
        t_partial();
        t_readback();
        t_plain();
        t_dual();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule